// File: doc/BRIEF.md
# Single-Transfer DMA Data Mover

This block carries out one programmed DMA cycle for a single channel over an AHB-Lite master port. The address and data buses are both 32 bits wide. A descriptor is presented on the inputs together with a one-cycle `start` strobe. The descriptor holds a source pointer, a destination pointer, a unit size, separate source and destination address increments, and a transfer count stored as count minus one. The block then performs that many transfers. Each transfer is one single read of the source followed by one single write of the destination, and both use the same unit size.

The increment settings select the pattern. Both pointers stepping gives memory-to-memory. A fixed destination gives memory-to-peripheral. A fixed source gives peripheral-to-memory. A step may be wider than the unit, which allows strided gathers and scatters.

The block raises a one-cycle `done` pulse when the final write completes. If the bus returns an error response, it abandons the cycle and holds `err` high. Fetching descriptors, register access and choosing between channels are handled elsewhere.

Top module: `dma_xfer_engine`

## Requirements
- R1: Every bus access is a single transfer. `hburst` is always 3'b000, and `htrans` is only ever 2'b00 (idle) or 2'b10 (non-sequential).
- R2: A cycle started with `xfer_m1` = N performs exactly N+1 read address phases and N+1 write address phases, strictly alternating and starting with a read. N = 0 gives one transfer and N = 1023 gives 1024.
- R3: The read and the write both use `hsize` = {1'b0, `unit_size`}, where `unit_size` is 0 for byte, 1 for halfword and 2 for word (3 is treated as word). The unit taken from the source byte lanes arrives unchanged at the destination address.
- R4: After every completed transfer each pointer advances by its own step. The step is given by the increment code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = no increment). A step narrower than the unit size is widened to the unit size.
- R5: While `hready` is low, an address phase holds `htrans`, `haddr` and `hwrite` unchanged, and read data is taken only in the cycle `hready` is high.
- R6: Write data appears on `hwdata` in the cycle after the write address phase is accepted, and is held through data-phase wait states.
- R7: If `hresp` is high during a data phase, the block ends the cycle at once and issues no further transfers. `err` goes high, no `done` pulse follows, `remain` keeps the count of transfers not completed, and `err` stays high until the next accepted `start`, which clears it.
- R8: When the last write completes, `done` is high for exactly one cycle, `busy` is low and `remain` reads zero.
- R9: A `start` strobe while `busy` is high is ignored. The running cycle keeps its descriptor.
- R10: After reset the block is idle: `busy`, `done` and `err` are low and `htrans` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the descriptor when idle |
| src_base | input | 32 | First source address |
| dst_base | input | 32 | First destination address |
| unit_size | input | 2 | Unit size code |
| src_inc | input | 2 | Source increment code |
| dst_inc | input | 2 | Destination increment code |
| xfer_m1 | input | 10 | Transfer count minus one |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Bus error seen, held until next start |
| remain | output | 11 | Transfers not yet completed |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Write when high |
| hsize | output | 3 | Access size |
| hburst | output | 3 | Burst type |
| hwdata | output | 32 | Write data |
| hrdata | input | 32 | Read data |
| hready | input | 1 | Transfer ready |
| hresp | input | 1 | Error response |

## Verification
The hardest situation to reach from the ports is an error response that arrives partway through a cycle, on either the read half or the write half of a transfer. The count of transfers already completed must be exact, and the error must be cleared by a later restart. The bench slave model returns a two-cycle error response for one chosen address. That address is placed on a chosen transfer's source pointer or on its destination pointer, and the slave also inserts varying wait states. The bench also injects a second `start` partway through a cycle, which covers the ignored-start case.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_ADDR = 3'd1,
    ST_RD_DATA = 3'd2,
    ST_WR_ADDR = 3'd3,
    ST_WR_DATA = 3'd4
  } xfer_state_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [1:0] INC_HOLD     = 2'd3;

  // Reserved size code 3 behaves as a word.
  function automatic logic [1:0] clamp_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // Byte step for one pointer: zero when held, never narrower than the unit.
  function automatic logic [2:0] step_bytes(input logic [1:0] inc_code,
                                            input logic [1:0] size_code);
    logic [1:0] sz;
    sz = clamp_size(size_code);
    if (inc_code == INC_HOLD) return 3'd0;
    if (inc_code > sz)        return 3'(1) << inc_code;
    return 3'(1) << sz;
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [1:0]    inc_code,
  input  logic [1:0]    size_code,
  input  logic          advance,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic [2:0]    step_q, step_d;
  logic          addr_en;

  assign addr_en = load | advance;

  always_comb begin
    addr_d = addr_q;
    step_d = step_q;
    if (load) begin
      addr_d = load_addr;
      step_d = step_bytes(inc_code, size_code);
    end else if (advance) begin
      addr_d = addr_q + AW'(step_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
      step_q <= step_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack #(
  parameter int DW = 32
) (
  input  logic [1:0]          size_code,
  input  logic [LW-1:0]       lane,
  input  logic [DW-1:0]       rdata,
  output logic [DW-1:0]       wdata
);

  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);

  logic [DW-1:0] shifted;

  // Move the addressed unit down to lane zero.
  assign shifted = rdata >> {lane, 3'b000};

  // Replicate the unit across all lanes so any destination alignment sees it.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      unique case (size_code)
        2'd0:    wdata[8*b +: 8] = shifted[7:0];
        2'd1:    wdata[8*b +: 8] = shifted[8*(b%2) +: 8];
        default: wdata[8*b +: 8] = rdata[8*b +: 8];
      endcase
    end
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CNT_W-1:0] count_m1,
  input  logic           hready,
  input  logic           hresp,
  output logic           load,
  output logic           advance,
  output logic           capture,
  output logic           addr_phase,
  output logic           use_dst,
  output logic           wr_phase,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [CNT_W:0] remain
);

  localparam int RW = CNT_W + 1;

  xfer_state_e   state_q, state_d;
  logic [RW-1:0] remain_q, remain_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          remain_en;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    done_d   = 1'b0;
    err_d    = err_q;
    load     = 1'b0;
    advance  = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load     = 1'b1;
          remain_d = RW'(count_m1) + RW'(1);
          err_d    = 1'b0;
          state_d  = ST_RD_ADDR;
        end
      end
      ST_RD_ADDR: begin
        if (hready) state_d = ST_RD_DATA;
      end
      ST_RD_DATA: begin
        if (hresp) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (hready) begin
          capture = 1'b1;
          state_d = ST_WR_ADDR;
        end
      end
      ST_WR_ADDR: begin
        if (hready) state_d = ST_WR_DATA;
      end
      ST_WR_DATA: begin
        if (hresp) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (hready) begin
          advance  = 1'b1;
          remain_d = remain_q - RW'(1);
          if (remain_q == RW'(1)) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_RD_ADDR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign remain_en = load | advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  assign addr_phase = (state_q == ST_RD_ADDR) || (state_q == ST_WR_ADDR);
  assign use_dst    = (state_q == ST_WR_ADDR) || (state_q == ST_WR_DATA);
  assign wr_phase   = (state_q == ST_WR_ADDR);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign remain     = remain_q;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [1:0]       unit_size,
  input  logic [1:0]       src_inc,
  input  logic [1:0]       dst_inc,
  input  logic [CNT_W-1:0] xfer_m1,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W:0]   remain,
  output logic [AW-1:0]    haddr,
  output logic [1:0]       htrans,
  output logic             hwrite,
  output logic [2:0]       hsize,
  output logic [2:0]       hburst,
  output logic [DW-1:0]    hwdata,
  input  logic [DW-1:0]    hrdata,
  input  logic             hready,
  input  logic             hresp
);

  localparam int LW = $clog2(DW / 8);

  logic          load, advance, capture, addr_phase, use_dst, wr_phase;
  logic [AW-1:0] src_addr, dst_addr;
  logic [1:0]    size_q, size_d;
  logic [DW-1:0] wdata_q, packed_unit;

  dma_xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .count_m1  (xfer_m1),
    .hready    (hready),
    .hresp     (hresp),
    .load      (load),
    .advance   (advance),
    .capture   (capture),
    .addr_phase(addr_phase),
    .use_dst   (use_dst),
    .wr_phase  (wr_phase),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .remain    (remain)
  );

  dma_addr_gen #(.AW(AW)) u_src_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_addr(src_base),
    .inc_code (src_inc),
    .size_code(unit_size),
    .advance  (advance),
    .addr     (src_addr)
  );

  dma_addr_gen #(.AW(AW)) u_dst_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_addr(dst_base),
    .inc_code (dst_inc),
    .size_code(unit_size),
    .advance  (advance),
    .addr     (dst_addr)
  );

  dma_lane_pack #(.DW(DW)) u_pack (
    .size_code(size_q),
    .lane     (src_addr[LW-1:0]),
    .rdata    (hrdata),
    .wdata    (packed_unit)
  );

  assign size_d = clamp_size(unit_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    size_q <= '0;
    else if (load) size_q <= size_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdata_q <= '0;
    else if (capture) wdata_q <= packed_unit;
  end

  assign haddr  = use_dst ? dst_addr : src_addr;
  assign htrans = addr_phase ? TRANS_NONSEQ : TRANS_IDLE;
  assign hwrite = wr_phase;
  assign hsize  = {1'b0, size_q};
  assign hburst = BURST_SINGLE;
  assign hwdata = wdata_q;

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
  parameter int AW    = 32,
  parameter int CNT_W = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [CNT_W:0] remain,
  input logic [AW-1:0]  haddr,
  input logic [1:0]     htrans,
  input logic           hwrite,
  input logic           hready,
  input logic           hresp
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !hready) |=>
      (htrans == 2'b10 && $stable(haddr) && $stable(hwrite)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remain == '0 && !busy));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(hresp));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> (htrans == 2'b00 && !done));

  // R9
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !hresp && remain > 1) |=> busy);

endmodule

bind dma_xfer_engine dma_xfer_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .remain(remain),
  .haddr (haddr),
  .htrans(htrans),
  .hwrite(hwrite),
  .hready(hready),
  .hresp (hresp)
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] src_base, dst_base;
  logic [1:0]  unit_size, src_inc, dst_inc;
  logic [9:0]  xfer_m1;
  logic        busy, done, err;
  logic [10:0] remain;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic        hwrite, hready, hresp;
  logic [2:0]  hsize, hburst;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base), .unit_size(unit_size),
    .src_inc(src_inc), .dst_inc(dst_inc), .xfer_m1(xfer_m1),
    .busy(busy), .done(done), .err(err), .remain(remain),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp)
  );

  // ---------------- slave memory model ----------------
  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic       dp_valid, dp_write;
  logic [7:0] dp_addr;
  logic [1:0] dp_size;
  int         dp_wait, err_stage, txn_seq;
  bit         ws_en, err_en;
  logic [7:0] err_addr;

  assign hresp  = (err_stage != 0);
  assign hready = (err_stage == 2) || (err_stage == 0 && !(dp_valid && dp_wait != 0));
  assign hrdata = {mem[{dp_addr[7:2], 2'd3}], mem[{dp_addr[7:2], 2'd2}],
                   mem[{dp_addr[7:2], 2'd1}], mem[{dp_addr[7:2], 2'd0}]};

  function automatic bit lane_on(input int i, input logic [1:0] sz, input logic [7:0] a);
    if (sz == 2'd0) return (i == int'(a[1:0]));
    if (sz == 2'd1) return (i / 2 == int'(a[1]));
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0; dp_write <= 1'b0; dp_addr <= '0; dp_size <= '0;
      dp_wait <= 0; err_stage <= 0; txn_seq <= 0;
    end else if (err_stage == 1) begin
      err_stage <= 2;
    end else if (hready) begin
      if (dp_valid && dp_write && err_stage == 0)
        for (int i = 0; i < 4; i++)
          if (lane_on(i, dp_size, dp_addr)) mem[{dp_addr[7:2], 2'(i)}] <= hwdata[8*i +: 8];
      err_stage <= 0;
      dp_valid  <= 1'b0;
      if (htrans[1]) begin
        dp_valid <= 1'b1;
        dp_write <= hwrite;
        dp_addr  <= haddr[7:0];
        dp_size  <= hsize[1:0];
        txn_seq  <= txn_seq + 1;
        dp_wait  <= ws_en ? (txn_seq % 3) : 0;
        if (err_en && haddr[7:0] == err_addr) begin
          err_stage <= 1;
          dp_wait   <= 0;
        end
      end
    end else begin
      dp_wait <= dp_wait - 1;
    end
  end

  // ---------------- bus monitor ----------------
  int         rd_cnt, wr_cnt, addr_bad, size_bad, burst_bad, order_bad;
  logic [7:0] m_src0, m_dst0;
  int         m_sstep, m_dstep;
  logic [1:0] m_size;
  bit         last_was_read;

  always @(posedge clk) begin
    if (rst_n) begin
      if (hburst != 3'b000 || htrans == 2'b01 || htrans == 2'b11) burst_bad++;
      if (htrans == 2'b10 && hready) begin
        if (hsize != {1'b0, m_size}) size_bad++;
        if (hwrite) begin
          if (haddr[7:0] != 8'(int'(m_dst0) + wr_cnt * m_dstep)) addr_bad++;
          if (!last_was_read) order_bad++;
          last_was_read = 1'b0;
          wr_cnt++;
        end else begin
          if (haddr[7:0] != 8'(int'(m_src0) + rd_cnt * m_sstep)) addr_bad++;
          if (last_was_read) order_bad++;
          last_was_read = 1'b1;
          rd_cnt++;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int step_of(input int inc, input int sz);
    int s;
    s = (sz == 3) ? 2 : sz;
    if (inc == 3) return 0;
    return (inc > s) ? (1 << inc) : (1 << s);
  endfunction

  task automatic run_one(input int sz, input int si, input int di, input int cm1,
                         input logic [7:0] s0, input logic [7:0] d0, input bit ws,
                         input bit e_en, input logic [7:0] e_addr, input bit poke,
                         input bit exp_done, input int exp_rd, input int exp_wr,
                         input int exp_rem, input int ncomp, input int seed);
    bit saw_done, saw_err;
    int n, rem_seen, w, ss, ds;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 37 + 11 + seed);
      exp_mem[i] = 8'(i * 37 + 11 + seed);
    end
    ss = step_of(si, sz); ds = step_of(di, sz);
    w  = 1 << ((sz == 3) ? 2 : sz);
    for (int k = 0; k < ncomp; k++)
      for (int b = 0; b < w; b++)
        exp_mem[8'(int'(d0) + k * ds + b)] = exp_mem[8'(int'(s0) + k * ss + b)];
    m_src0 = s0; m_dst0 = d0; m_sstep = ss; m_dstep = ds; m_size = 2'((sz == 3) ? 2 : sz);
    rd_cnt = 0; wr_cnt = 0; addr_bad = 0; size_bad = 0; burst_bad = 0; order_bad = 0;
    last_was_read = 1'b0;
    ws_en = ws; err_en = e_en; err_addr = e_addr;
    @(negedge clk);
    src_base = {24'h0, s0}; dst_base = {24'h0, d0};
    unit_size = 2'(sz); src_inc = 2'(si); dst_inc = 2'(di); xfer_m1 = 10'(cm1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    saw_done = 0; saw_err = 0; n = 0; rem_seen = -1;
    while (!saw_done && !saw_err && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 4) begin
        start = 1'b1; dst_base = 32'hC0; xfer_m1 = 10'd0; dst_inc = 2'd3;
      end
      if (poke && n == 5) start = 1'b0;
      if (done) begin saw_done = 1; rem_seen = int'(remain); end
      else if (err) begin saw_err = 1; rem_seen = int'(remain); end
    end
    check(n < 20000, "WD", "watchdog cycles", n, 20000);
    if (exp_done) begin
      check(saw_done && !err, "R8", "done seen without err", saw_done, 1);
      check(rem_seen == 0, "R8", "remain at done", rem_seen, 0);
      check(!busy, "R8", "busy at done", busy, 0);
      @(negedge clk);
      check(!done, "R8", "done width one cycle", done, 0);
    end else begin
      check(saw_err && !saw_done, "R7", "err without done", saw_err, 1);
      check(rem_seen == exp_rem, "R7", "remain after error", rem_seen, exp_rem);
      repeat (4) @(negedge clk);
      check(err && !done && htrans == 2'b00, "R7", "err held, bus idle", err, 1);
    end
    check(rd_cnt == exp_rd, "R2", "read phases", rd_cnt, exp_rd);
    check(wr_cnt == exp_wr, "R2", "write phases", wr_cnt, exp_wr);
    check(order_bad == 0, "R2", "read/write alternation errors", order_bad, 0);
    check(burst_bad == 0, "R1", "non-single transfer cycles", burst_bad, 0);
    check(size_bad == 0, "R3", "hsize mismatches", size_bad, 0);
    check(addr_bad == 0, "R4", "address step mismatches", addr_bad, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      check(bad == 0, ws ? "R6" : "R3", "memory bytes differing", bad, 0);
    end
    err_en = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL WD global watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int seed;
    rst_n = 1'b0; start = 1'b0; src_base = '0; dst_base = '0;
    unit_size = '0; src_inc = '0; dst_inc = '0; xfer_m1 = '0;
    ws_en = 0; err_en = 0; err_addr = '0;
    m_src0 = '0; m_dst0 = '0; m_sstep = 0; m_dstep = 0; m_size = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && htrans == 2'b00, "R10", "idle during reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !err && htrans == 2'b00, "R10", "idle after reset", htrans, 0);

    // R2 R3 R4 R6: sweep sizes, both increments and two counts
    seed = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int si = 0; si < 4; si++)
        for (int di = 0; di < 4; di++)
          for (int c = 0; c < 2; c++) begin
            seed++;
            run_one(sz, si, di, c * 2, 8'h08, 8'h84, ((si + di + c) % 2) == 1,
                    0, 8'h00, 0, 1, c * 2 + 1, c * 2 + 1, 0, c * 2 + 1, seed);
          end

    // R2: largest count, fixed pointers both sides
    run_one(2, 3, 3, 1023, 8'h10, 8'h90, 0, 0, 8'h00, 0, 1, 1024, 1024, 0, 1024, 7);

    // R7: error on the read of transfer 2
    run_one(2, 2, 2, 7, 8'h20, 8'hA0, 1, 1, 8'h28, 0, 0, 3, 2, 6, 2, 11);
    // R7: next start clears err and completes
    run_one(1, 1, 1, 3, 8'h02, 8'h82, 0, 0, 8'h00, 0, 1, 4, 4, 0, 4, 12);
    // R7: error on the write of transfer 1
    run_one(0, 0, 2, 5, 8'h30, 8'hB0, 0, 1, 8'hB4, 0, 0, 2, 2, 5, 1, 13);

    // R9: start strobe while busy is ignored
    run_one(2, 2, 2, 5, 8'h40, 8'h88, 1, 0, 8'h00, 1, 1, 6, 6, 0, 6, 14);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule